// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block supervises each transmit attempt of a half-duplex Ethernet MAC. From the first preamble bit of an attempt it counts bit times on a bit strobe. It watches the collision input and sorts each collision into one of two kinds. A collision inside the first slot time is early: the block asks the transmit FIFO to rewind to the start of the frame, waits a random backoff and starts a new attempt. A collision after the slot time is late: the frame is dropped and reported.

The block also tells the FIFO when bytes already sent may be released for overwrite. In half-duplex mode it holds that release until a full slot time (64 bytes, preamble included) has gone out with no collision. When retries are disabled, or the link is full duplex, collisions are ignored and release is granted from the first bit. Each frame ends with a one-cycle done pulse. Two status flags ride on that pulse, one for retry exhaustion and one for late collision. The descriptor logic outside the block uses them to close the current buffer and skip the rest of the frame.

Top module: `hd_collision_retry`

## Requirements
- R1: After a synchronous active-low reset, tx_active, rewind, release_ok, frame_done, stat_exhaust and stat_late are 0 and attempt is 0.
- R2: With the block idle, frame_req high at a clock edge starts an attempt: from the next cycle tx_active is 1 and attempt is 1.
- R3: In half-duplex mode (retry_dis = 0 and full_dup = 0), release_ok stays 0 during an attempt until SLOT_BITS bit_tick pulses have been counted since the attempt began. It is 1 from then until the attempt ends. Cycles without bit_tick do not advance the count.
- R4: With retry_dis = 1 or full_dup = 1, release_ok is 1 for the whole attempt and collisions are ignored: no rewind, no done pulse, and the attempt goes on until frame_last.
- R5: In half-duplex mode, a collision seen while fewer than SLOT_BITS bit ticks have been counted, with attempt below MAX_ATT, gives the following: rewind is 1 for exactly one cycle, tx_active drops in that same cycle, and attempt increases by one.
- R6: After an early collision that is the n-th collision of the frame, the next attempt starts r*SLOT_BITS bit ticks after the rewind cycle, plus one cycle. Here r is an integer from 0 to 2^min(n,BO_CAP)-1.
- R7: In half-duplex mode, a collision seen once SLOT_BITS bit ticks have been counted ends the frame. The next cycle has frame_done = 1 and stat_late = 1, with no rewind and no further attempt.
- R8: An early collision during attempt MAX_ATT (16 by default: the first try plus 15 retries) ends the frame. The next cycle has frame_done = 1, stat_exhaust = 1, no rewind, and attempt still equal to MAX_ATT.
- R9: frame_last during an attempt with no collision counted in the same cycle ends the frame. The next cycle has frame_done = 1 and both status flags 0.
- R10: frame_done and the status flags are 1 for a single cycle only. Status flags are never 1 without frame_done. After the done cycle the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One pulse per transmitted bit time |
| frame_req | input | 1 | A frame is ready to transmit |
| frame_last | input | 1 | Last bit of the frame has been sent |
| col | input | 1 | Collision detected on the medium |
| retry_dis | input | 1 | Disable collision handling and retries |
| full_dup | input | 1 | Link operates in full duplex |
| tx_active | output | 1 | An attempt is in progress |
| rewind | output | 1 | One-cycle request to return the FIFO read pointer to frame start |
| release_ok | output | 1 | Sent bytes may be released for overwrite |
| frame_done | output | 1 | One-cycle pulse: frame finished |
| stat_exhaust | output | 1 | With frame_done: all attempts failed |
| stat_late | output | 1 | With frame_done: late collision |
| attempt | output | clog2(MAX_ATT+1) | Number of the current attempt |

## Verification
Some rules are checked by assertions on every cycle. The done and status flags must appear only as single-cycle pulses, and status must never show without done. A rewind must follow only a half-duplex collision and must drop tx_active. The attempt count and the slot counter must stay in range, and the loaded backoff must never exceed its cap. Other behaviour can only be shown by the bench's scenarios. These include exactly where the early/late boundary falls against the bit count, and release timing when bit ticks are irregular. They also include the backoff gap being a whole number of slots within the allowed window, exhaustion on the sixteenth attempt, and collisions being ignored in full duplex or with retries disabled.

// File: rtl/hd_retry_pkg.sv
// Shared types for the half-duplex collision retry controller.
package hd_retry_pkg;
    // Controller phase: idle, sending an attempt, or waiting out a backoff.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2
    } hd_phase_t;
endpackage

// File: rtl/hd_slot_timer.sv
// Counts bit ticks from the first preamble bit of an attempt, saturating at
// one slot time. Assumes restart is held whenever no attempt is in progress,
// so every attempt begins with a zero count.
module hd_slot_timer #(
    parameter int SLOT_BITS = 512,
    localparam int CW = $clog2(SLOT_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic slot_done
);
    logic [CW-1:0] bit_cnt;

    // Advance on each bit tick; clear between attempts; hold at one slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (restart)
            bit_cnt <= '0;
        else if (tick && (bit_cnt != CW'(SLOT_BITS)))
            bit_cnt <= bit_cnt + 1'b1;
    end

    assign slot_done = (bit_cnt == CW'(SLOT_BITS));

    AST_SLOT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(SLOT_BITS)); // R3
    AST_SLOT_NO_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (bit_cnt >= $past(bit_cnt))); // R3
endmodule

// File: rtl/hd_attempt_ctr.sv
// Counts transmit attempts of the current frame. The first pulse loads one,
// and each bump adds one up to MAX_ATT. last flags the final permitted attempt.
module hd_attempt_ctr #(
    parameter int MAX_ATT = 16,
    localparam int AW = $clog2(MAX_ATT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          first,
    input  logic          bump,
    output logic [AW-1:0] count,
    output logic          last
);
    // Load on frame start, step on each retry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (first)
            count <= AW'(1);
        else if (bump && (count != AW'(MAX_ATT)))
            count <= count + 1'b1;
    end

    assign last = (count == AW'(MAX_ATT));

    AST_ATT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= AW'(MAX_ATT)); // R8
    AST_ATT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !first && !last) |=> (count == $past(count) + 1'b1)); // R5
endmodule

// File: rtl/hd_backoff.sv
// Truncated binary exponential backoff. On load it draws r from a free-running
// LFSR and masks r to min(ncol, CAP) bits. It then counts r slot times of bit
// ticks down to zero. Assumes CAP is at most 16, the LFSR width.
module hd_backoff #(
    parameter int          SLOT_BITS = 512,
    parameter int          CAP       = 10,
    parameter int          AW        = 5,
    parameter logic [15:0] SEED      = 16'hACE1,
    localparam int RMW = CAP + $clog2(SLOT_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ncol,
    input  logic          tick,
    output logic          expired
);
    logic [15:0]    lfsr;
    logic [CAP-1:0] range_mask;
    logic [CAP-1:0] slots;
    logic [RMW-1:0] remaining;

    // Free-running pseudo-random source, polynomial x^16+x^14+x^13+x^11+1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr <= SEED;
        else
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // Mask bit g is open once the frame has seen more than g collisions.
    for (genvar g = 0; g < CAP; g++) begin : g_mask
        assign range_mask[g] = (32'(ncol) > g);
    end

    assign slots = lfsr[CAP-1:0] & range_mask;

    // Load the wait in bit times, then count it down on bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= RMW'(slots) * RMW'(SLOT_BITS);
        else if (tick && (remaining != '0))
            remaining <= remaining - 1'b1;
    end

    assign expired = (remaining == '0);

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= RMW'((2 ** CAP - 1) * SLOT_BITS)); // R6
endmodule

// File: rtl/hd_collision_retry.sv
// Half-duplex transmit attempt supervisor. Sorts collisions into early
// (rewind, back off, retry) and late (abandon). Gives up after MAX_ATT
// attempts and grants FIFO release once a slot time is safely out.
// Assumes frame_last and col are already qualified by the MAC. The FIFO
// acts on rewind in the cycle it is high.
module hd_collision_retry
    import hd_retry_pkg::*;
#(
    parameter int          SLOT_BITS = 512,
    parameter int          MAX_ATT   = 16,
    parameter int          BO_CAP    = 10,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_tick,
    input  logic                           frame_req,
    input  logic                           frame_last,
    input  logic                           col,
    input  logic                           retry_dis,
    input  logic                           full_dup,
    output logic                           tx_active,
    output logic                           rewind,
    output logic                           release_ok,
    output logic                           frame_done,
    output logic                           stat_exhaust,
    output logic                           stat_late,
    output logic [$clog2(MAX_ATT+1)-1:0]   attempt
);
    localparam int AW = $clog2(MAX_ATT + 1);

    hd_phase_t phase, phase_nx;
    logic      sending, half_mode, slot_done, att_last, bo_expired;
    logic      col_hit, ev_retry, ev_exhaust, ev_late, ev_finish, ev_end;

    assign sending   = (phase == PH_SEND);
    assign half_mode = !(retry_dis || full_dup);

    // Classify the events of the current send cycle.
    always_comb begin
        col_hit    = sending && half_mode && col;
        ev_retry   = col_hit && !slot_done && !att_last;
        ev_exhaust = col_hit && !slot_done &&  att_last;
        ev_late    = col_hit &&  slot_done;
        ev_finish  = sending && !col_hit && frame_last;
        ev_end     = ev_exhaust || ev_late || ev_finish;
    end

    hd_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (!sending),
        .tick      (bit_tick && sending),
        .slot_done (slot_done)
    );

    hd_attempt_ctr #(.MAX_ATT(MAX_ATT)) u_att (
        .clk   (clk),
        .rst_n (rst_n),
        .first ((phase == PH_IDLE) && frame_req),
        .bump  (ev_retry),
        .count (attempt),
        .last  (att_last)
    );

    hd_backoff #(.SLOT_BITS(SLOT_BITS), .CAP(BO_CAP), .AW(AW), .SEED(LFSR_SEED)) u_bo (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ev_retry),
        .ncol    (attempt),
        .tick    (bit_tick && (phase == PH_WAIT)),
        .expired (bo_expired)
    );

    // Next phase of the attempt sequence.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (frame_req)  phase_nx = PH_SEND;
            PH_SEND: if (ev_retry)   phase_nx = PH_WAIT;
                     else if (ev_end) phase_nx = PH_IDLE;
            PH_WAIT: if (bo_expired) phase_nx = PH_SEND;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // One-cycle rewind, done and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rewind       <= 1'b0;
            frame_done   <= 1'b0;
            stat_exhaust <= 1'b0;
            stat_late    <= 1'b0;
        end else begin
            rewind       <= ev_retry;
            frame_done   <= ev_end;
            stat_exhaust <= ev_exhaust;
            stat_late    <= ev_late;
        end
    end

    assign tx_active  = sending;
    assign release_ok = sending && (!half_mode || slot_done);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R10
    AST_STATUS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_exhaust || stat_late) |-> frame_done); // R10
    AST_REWIND_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |-> ($past(half_mode) && !tx_active && !frame_done)); // R4
    AST_REWIND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> !rewind); // R5
    AST_EXHAUST_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        stat_exhaust |-> (attempt == AW'(MAX_ATT))); // R8
    AST_LATE_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        stat_late |-> (!rewind && !stat_exhaust)); // R7
endmodule

// File: tb/hd_collision_retry_tb.sv
module hd_collision_retry_tb_top;
    localparam int S   = 16;
    localparam int MAX = 16;
    localparam int CAP = 3;

    logic clk = 1'b0;
    logic rst_n, bit_tick, frame_req, frame_last, col, retry_dis, full_dup;
    logic tx_active, rewind, release_ok, frame_done, stat_exhaust, stat_late;
    logic [4:0] attempt;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hd_collision_retry #(.SLOT_BITS(S), .MAX_ATT(MAX), .BO_CAP(CAP), .LFSR_SEED(16'h1D2B)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_req(frame_req),
        .frame_last(frame_last), .col(col), .retry_dis(retry_dis), .full_dup(full_dup),
        .tx_active(tx_active), .rewind(rewind), .release_ok(release_ok),
        .frame_done(frame_done), .stat_exhaust(stat_exhaust), .stat_late(stat_late),
        .attempt(attempt)
    );

    function automatic int bo_limit(input int n);
        int k = (n < CAP) ? n : CAP;
        return (1 << k) - 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Start a frame: from the idle state, expect an attempt from the next cycle.
    task automatic start_frame();
        frame_req = 1'b1;
        @(negedge clk);
        chk("R2 start", {tx_active, attempt}, {1'b1, 5'd1});
        frame_req = 1'b0;
    endtask

    // One attempt: j bit times go out, then a collision or the last bit.
    task automatic run_attempt(input int j, input bit use_col, input int exp_att, output bit cont);
        bit nohalf = retry_dis || full_dup;
        bit early  = use_col && !nohalf && (j < S);
        bit late   = use_col && !nohalf && (j >= S);
        int g;
        cont = 1'b0;
        for (int k = 0; k < j; k++) begin
            chk(nohalf ? "R4 release" : "R3 release", release_ok, (nohalf || k >= S) ? 1 : 0);
            @(negedge clk);
        end
        if (use_col) col = 1'b1; else frame_last = 1'b1;
        @(negedge clk);
        col = 1'b0;
        frame_last = 1'b0;
        if (use_col && nohalf) begin
            chk("R4 ignored", {rewind, frame_done, tx_active}, 3'b001);
            frame_last = 1'b1;
            @(negedge clk);
            frame_last = 1'b0;
            chk("R9 done", {frame_done, stat_exhaust, stat_late}, 3'b100);
        end else if (early && exp_att < MAX) begin
            chk("R5 rewind", {rewind, tx_active, frame_done}, 3'b100);
            chk("R5 attempt", attempt, exp_att + 1);
            g = 0;
            @(negedge clk);
            g++;
            chk("R5 pulse", rewind, 0);
            while (!tx_active && g < 100000) begin
                @(negedge clk);
                g++;
            end
            chk("R6 whole slots", (g - 1) % S, 0);
            chk("R6 window", ((g - 1) / S) <= bo_limit(exp_att), 1);
            cont = 1'b1;
            return;
        end else if (early) begin
            chk("R8 exhaust", {frame_done, stat_exhaust, stat_late, rewind}, 4'b1100);
            chk("R8 attempt", attempt, MAX);
        end else if (late) begin
            chk("R7 late", {frame_done, stat_exhaust, stat_late, rewind}, 4'b1010);
        end else begin
            chk("R9 done", {frame_done, stat_exhaust, stat_late}, 3'b100);
        end
        @(negedge clk);
        chk("R10 single", {frame_done, stat_exhaust, stat_late, tx_active}, 4'b0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        bit cont;
        int t, att;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; bit_tick = 1'b1; frame_req = 1'b1; frame_last = 1'b0;
        col = 1'b1; retry_dis = 1'b0; full_dup = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset", {tx_active, rewind, release_ok, frame_done, stat_exhaust, stat_late, attempt},
            11'd0);
        frame_req = 1'b0; col = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Clean frame, then late collision exactly at the slot boundary.
        start_frame(); run_attempt(S + 3, 1'b0, 1, cont);
        start_frame(); run_attempt(S, 1'b1, 1, cont);
        // Early collision at the last early bit, then a clean finish.
        start_frame(); run_attempt(S - 1, 1'b1, 1, cont);
        run_attempt(S + 1, 1'b0, 2, cont);
        // Exhaustion: every attempt collides early.
        start_frame();
        for (int a = 1; a <= MAX; a++) run_attempt(2, 1'b1, a, cont);
        chk("R8 no retry", cont, 0);
        // Full duplex and disabled retry ignore collisions.
        full_dup = 1'b1; start_frame(); run_attempt(3, 1'b1, 1, cont); full_dup = 1'b0;
        retry_dis = 1'b1; start_frame(); run_attempt(0, 1'b1, 1, cont); retry_dis = 1'b0;

        // Irregular bit ticks: release follows ticks, not cycles.
        start_frame();
        t = 0;
        for (int c = 0; c < 3 * S; c++) begin
            chk("R3 ticks", release_ok, (t >= S) ? 1 : 0);
            bit_tick = ($urandom % 3) == 0;
            t += bit_tick;
            @(negedge clk);
        end
        bit_tick = 1'b1;
        frame_last = 1'b1; @(negedge clk); frame_last = 1'b0;
        chk("R9 done", {frame_done, stat_exhaust, stat_late}, 3'b100);
        @(negedge clk);

        // Random frames across modes and collision positions.
        for (int f = 0; f < 40; f++) begin
            int mode = $urandom % 4;
            retry_dis = (mode == 2);
            full_dup  = (mode == 3);
            start_frame();
            att = 1;
            cont = 1'b1;
            while (cont) begin
                run_attempt($urandom % (2 * S + 2), ($urandom % 2) == 1, att, cont);
                att++;
            end
        end
        summary();
    end
endmodule